// File: doc/BRIEF.md
# USB IN Endpoint Transmit Buffer Controller

This block owns the transmit memory of one device IN endpoint. A processor-side port pushes bytes into a two-half memory and marks a loaded half as ready. The block reports how full it is through a 2-bit occupancy code. It runs as a single buffer or a ping-pong pair. It can also mark data ready by itself once a configured byte count is reached. In a segmented mode, one loaded data set of up to the buffer size is sent to the host as a series of max-size packets.

The link layer reads the current packet through a byte-strobe port and sees its length on `tx_len`. It rewinds the packet with `tx_restart` when a retransmission is needed. It confirms delivery with `tx_ack`. Occupancy drops only on that confirmation. While the buffer is empty, `tx_avail` is low, and the link layer answers the host's IN token with NAK. Serial signalling, token and PID handling and CRC are outside the block.

Top module: `ep_in_buf_ctrl`

## Requirements
- R1: Synchronous `rst` or `flush` clears the byte counts, both half pointers, the overrun flag and the status. The next cycle shows `sts`=00 and `tx_avail`=0.
- R2: With `cfg_dbl`=0, a set-ready moves `sts` from 00 to 11, and one `tx_ack` moves it from 11 back to 00. In this mode `sts` never reads 01.
- R3: With `cfg_dbl`=1, each commit moves `sts` 00→01→11. Each `tx_ack` moves it 11→01→00. The halves are sent in the order they were committed.
- R4: Reading bytes or restarting a packet never changes `sts`. Only a commit, an acknowledge or a flush does.
- R5: With `cfg_auto`=0, writes alone never change `sts`. A one-cycle pulse on `cpu_set_rdy` is needed.
- R6: With `cfg_auto`=1 and `cfg_cont`=0, the write that brings the half's count to `cfg_maxp` commits it. A shorter half still needs `cpu_set_rdy`.
- R7: With `cfg_cont`=1, a committed set of L bytes goes out as ceil(L/`cfg_maxp`) packets. Each packet is `cfg_maxp` bytes long except the last, which carries the remainder. `sts` holds until the final packet is acknowledged.
- R8: With `cfg_auto`=1 and `cfg_cont`=1, the write that brings the count to `cfg_bufsz` commits the half. Fewer bytes leave `sts` unchanged.
- R9: Pulsing `tx_rd` returns the next byte of the current packet on `tx_data` one clock later. Bytes come back in write order, and `tx_len` gives the packet length.
- R10: While `sts` is 00, `tx_avail` is 0.
- R11: A write while `sts`=11 is dropped. It sets the sticky `overrun` flag and leaves the queued packet's length and bytes unchanged.
- R12: `tx_restart` rewinds the current packet so that the next read returns its first byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| flush | input | 1 | endpoint flush, same effect as reset |
| cfg_dbl | input | 1 | 1 = two halves (ping-pong), 0 = one buffer |
| cfg_auto | input | 1 | commit automatically when a byte count is reached |
| cfg_cont | input | 1 | segment a data set into max-size packets |
| cfg_maxp | input | CW | max packet size in bytes |
| cfg_bufsz | input | CW | data set size, a multiple of cfg_maxp |
| cpu_wr | input | 1 | byte write strobe |
| cpu_wdata | input | DW | byte to store |
| cpu_set_rdy | input | 1 | self-clearing set-ready pulse |
| sts | output | 2 | occupancy code 00/01/11 |
| overrun | output | 1 | sticky: a write was dropped |
| tx_avail | output | 1 | a packet is ready for the host |
| tx_len | output | CW | length of the current packet |
| tx_rd | input | 1 | fetch next byte of the current packet |
| tx_data | output | DW | byte fetched by the previous tx_rd |
| tx_restart | input | 1 | rewind the current packet |
| tx_ack | input | 1 | host acknowledged the current packet |

## Verification
The hardest state to reach is a segmented set partway through. Several packets have already been acknowledged, the offset sits deep inside the half, and the last packet is short. This state shows only while the status stays at 11. The bench reaches it by sweeping the set length over every value from 1 to the half depth. For each length it drains the set packet by packet, checking each length, every byte and the status after each acknowledge. Double-buffer ordering is reached by committing two halves of different lengths before the first acknowledge.

// File: rtl/ep_in_pkg.sv
package ep_in_pkg;
  localparam logic [1:0] STS_EMPTY = 2'b00;
  localparam logic [1:0] STS_ONE   = 2'b01;
  localparam logic [1:0] STS_FULL  = 2'b11;

  function automatic logic [1:0] sts_enc(input logic [1:0] occ, input logic dbl);
    if (occ == 2'd0)                 return STS_EMPTY;
    else if (dbl && occ == 2'd1)     return STS_ONE;
    else                             return STS_FULL;
  endfunction
endpackage

// File: rtl/ep_in_ram.sv
module ep_in_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ep_in_wr.sv
module ep_in_wr #(
  parameter int HD = 16,
  parameter int CW = $clog2(HD + 1),
  parameter int AW = $clog2(2 * HD)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                cfg_dbl,
  input  logic                cfg_auto,
  input  logic                cfg_cont,
  input  logic [CW-1:0]       cfg_maxp,
  input  logic [CW-1:0]       cfg_bufsz,
  input  logic                cpu_wr,
  input  logic                cpu_set_rdy,
  input  logic                full,
  input  logic                free_en,
  input  logic                free_sel,
  output logic                commit,
  output logic                wr_drop,
  output logic                mem_we,
  output logic [AW-1:0]       mem_waddr,
  output logic [1:0][CW-1:0]  cnt
);
  logic          wsel;
  logic [CW-1:0] cur, cnt_after, target;
  logic          accept, auto_hit;

  always_comb begin
    cur       = cnt[wsel];
    accept    = cpu_wr && !full && (cur < CW'(HD));
    cnt_after = cur + CW'(accept);
    target    = cfg_cont ? cfg_bufsz : cfg_maxp;
    auto_hit  = cfg_auto && accept && (cnt_after == target);
    commit    = !full && (cpu_set_rdy || auto_hit);
    wr_drop   = cpu_wr && !accept;
    mem_we    = accept;
    mem_waddr = (wsel ? AW'(HD) : AW'(0)) + AW'(cur);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt  <= '0;
      wsel <= 1'b0;
    end else begin
      if (accept) cnt[wsel] <= cnt_after;
      if (free_en) cnt[free_sel] <= '0;
      if (commit && cfg_dbl) wsel <= ~wsel;
    end
  end
endmodule

// File: rtl/ep_in_rd.sv
module ep_in_rd #(
  parameter int HD = 16,
  parameter int CW = $clog2(HD + 1),
  parameter int AW = $clog2(2 * HD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          cfg_dbl,
  input  logic          cfg_cont,
  input  logic [CW-1:0] cfg_maxp,
  input  logic          occ_nz,
  input  logic [CW-1:0] cnt_cur,
  input  logic          tx_rd,
  input  logic          tx_restart,
  input  logic          tx_ack,
  output logic          rsel,
  output logic          free_en,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] tx_len
);
  logic [CW-1:0] off, bp, remain;
  logic          more, ack_ok;

  always_comb begin
    remain  = cnt_cur - off;
    more    = cfg_cont && (remain > cfg_maxp);
    tx_len  = more ? cfg_maxp : remain;
    ack_ok  = tx_ack && occ_nz;
    free_en = ack_ok && !more;
    re      = tx_rd && occ_nz && (bp < tx_len);
    raddr   = (rsel ? AW'(HD) : AW'(0)) + AW'(off) + AW'(bp);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      off  <= '0;
      bp   <= '0;
      rsel <= 1'b0;
    end else if (ack_ok) begin
      bp <= '0;
      if (more) begin
        off <= off + cfg_maxp;
      end else begin
        off <= '0;
        if (cfg_dbl) rsel <= ~rsel;
      end
    end else if (tx_restart) begin
      bp <= '0;
    end else if (re) begin
      bp <= bp + CW'(1);
    end
  end
endmodule

// File: rtl/ep_in_buf_ctrl.sv
module ep_in_buf_ctrl
  import ep_in_pkg::*;
#(
  parameter int DW = 8,
  parameter int HD = 16,
  parameter int CW = $clog2(HD + 1),
  parameter int AW = $clog2(2 * HD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          cfg_dbl,
  input  logic          cfg_auto,
  input  logic          cfg_cont,
  input  logic [CW-1:0] cfg_maxp,
  input  logic [CW-1:0] cfg_bufsz,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_set_rdy,
  output logic [1:0]    sts,
  output logic          overrun,
  output logic          tx_avail,
  output logic [CW-1:0] tx_len,
  input  logic          tx_rd,
  output logic [DW-1:0] tx_data,
  input  logic          tx_restart,
  input  logic          tx_ack
);
  logic [1:0]          occ, occ_nxt;
  logic                full, commit, wr_drop, free_en, rsel;
  logic                mem_we, mem_re;
  logic [AW-1:0]       mem_waddr, mem_raddr;
  logic [1:0][CW-1:0]  cnt;

  assign full = cfg_dbl ? (occ == 2'd2) : (occ == 2'd1);

  ep_in_wr #(.HD(HD), .CW(CW), .AW(AW)) u_wr (
    .clk(clk), .rst(rst), .flush(flush),
    .cfg_dbl(cfg_dbl), .cfg_auto(cfg_auto), .cfg_cont(cfg_cont),
    .cfg_maxp(cfg_maxp), .cfg_bufsz(cfg_bufsz),
    .cpu_wr(cpu_wr), .cpu_set_rdy(cpu_set_rdy), .full(full),
    .free_en(free_en), .free_sel(rsel),
    .commit(commit), .wr_drop(wr_drop),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .cnt(cnt)
  );

  ep_in_rd #(.HD(HD), .CW(CW), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .flush(flush),
    .cfg_dbl(cfg_dbl), .cfg_cont(cfg_cont), .cfg_maxp(cfg_maxp),
    .occ_nz(occ != 2'd0), .cnt_cur(cnt[rsel]),
    .tx_rd(tx_rd), .tx_restart(tx_restart), .tx_ack(tx_ack),
    .rsel(rsel), .free_en(free_en),
    .re(mem_re), .raddr(mem_raddr), .tx_len(tx_len)
  );

  ep_in_ram #(.DW(DW), .DEPTH(2 * HD), .AW(AW)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(cpu_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(tx_data)
  );

  always_comb begin
    occ_nxt = occ + 2'(commit) - 2'(free_en);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      occ      <= 2'd0;
      sts      <= STS_EMPTY;
      tx_avail <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      occ      <= occ_nxt;
      sts      <= sts_enc(occ_nxt, cfg_dbl);
      tx_avail <= (occ_nxt != 2'd0);
      if (wr_drop) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/ep_in_buf_chk.sv
module ep_in_buf_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          cfg_dbl,
  input logic          cfg_cont,
  input logic [CW-1:0] cfg_maxp,
  input logic          cpu_wr,
  input logic          cpu_set_rdy,
  input logic [1:0]    sts,
  input logic          overrun,
  input logic          tx_avail,
  input logic [CW-1:0] tx_len,
  input logic          tx_ack
);
  a_r1_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (sts == 2'b00 && !tx_avail && !overrun));

  a_r2_single_no_01: assert property (@(posedge clk) disable iff (rst)
    !cfg_dbl |-> sts != 2'b01);

  a_r3_dbl_one_step: assert property (@(posedge clk) disable iff (rst)
    (cfg_dbl && sts == 2'b00) |=> sts != 2'b11);

  a_r4_sts_holds: assert property (@(posedge clk) disable iff (rst)
    (!tx_ack && !cpu_set_rdy && !cpu_wr && !flush) |=> $stable(sts));

  a_r7_seg_len: assert property (@(posedge clk) disable iff (rst)
    (cfg_cont && tx_avail) |-> tx_len <= cfg_maxp);

  a_r10_empty_nak: assert property (@(posedge clk) disable iff (rst)
    (sts == 2'b00) |-> !tx_avail);

  a_r11_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && sts == 2'b11 && !flush) |=> overrun);

  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !flush) |=> overrun);
endmodule

bind ep_in_buf_ctrl ep_in_buf_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .cfg_dbl(cfg_dbl), .cfg_cont(cfg_cont),
  .cfg_maxp(cfg_maxp), .cpu_wr(cpu_wr), .cpu_set_rdy(cpu_set_rdy),
  .sts(sts), .overrun(overrun), .tx_avail(tx_avail), .tx_len(tx_len),
  .tx_ack(tx_ack)
);

// File: tb/sim_ep_in_buf_ctrl.sv
module sim_ep_in_buf_ctrl;
  localparam int DW = 8;
  localparam int HD = 16;
  localparam int CW = $clog2(HD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1, flush = 1'b0;
  logic cfg_dbl = 1'b0, cfg_auto = 1'b0, cfg_cont = 1'b0;
  logic [CW-1:0] cfg_maxp = CW'(8), cfg_bufsz = CW'(16);
  logic cpu_wr = 1'b0, cpu_set_rdy = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [1:0] sts;
  logic overrun, tx_avail;
  logic [CW-1:0] tx_len;
  logic tx_rd = 1'b0, tx_restart = 1'b0, tx_ack = 1'b0;
  logic [DW-1:0] tx_data;

  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  ep_in_buf_ctrl #(.DW(DW), .HD(HD)) u0 (
    .clk(clk), .rst(rst), .flush(flush), .cfg_dbl(cfg_dbl), .cfg_auto(cfg_auto),
    .cfg_cont(cfg_cont), .cfg_maxp(cfg_maxp), .cfg_bufsz(cfg_bufsz),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_set_rdy(cpu_set_rdy),
    .sts(sts), .overrun(overrun), .tx_avail(tx_avail), .tx_len(tx_len),
    .tx_rd(tx_rd), .tx_data(tx_data), .tx_restart(tx_restart), .tx_ack(tx_ack)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 13 + 5) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    cpu_wr = 1'b1; cpu_wdata = b;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic load(input int seed, input int n);
    for (int i = 0; i < n; i++) wr_byte(pat(seed, i));
  endtask

  task automatic pulse_rdy();
    cpu_set_rdy = 1'b1; @(negedge clk); cpu_set_rdy = 1'b0;
  endtask

  task automatic pulse_ack();
    tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    tx_rd = 1'b1; @(negedge clk); tx_rd = 1'b0; b = tx_data;
  endtask

  task automatic set_cfg(input logic d, input logic a, input logic c,
                         input int mp, input int bs);
    flush = 1'b1; @(negedge clk);
    cfg_dbl = d; cfg_auto = a; cfg_cont = c;
    cfg_maxp = CW'(mp); cfg_bufsz = CW'(bs);
    @(negedge clk); flush = 1'b0;
  endtask

  // read a whole packet and compare bytes start..start+n-1 of pattern seed
  task automatic drain_pkt(input string req, input int seed, input int start, input int n);
    logic [7:0] b;
    int errs = 0;
    for (int j = 0; j < n; j++) begin
      rd_byte(b);
      if (b != pat(seed, start + j)) errs++;
    end
    check(req, errs, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R10
    check("R1 sts after reset", sts, 0);
    check("R10 avail when empty", tx_avail, 0);
    check("R1 overrun after reset", overrun, 0);

    // R2 R5 R9 R4: single buffer, manual ready, every length 1..8
    set_cfg(0, 0, 0, 8, 16);
    for (int len = 1; len <= 8; len++) begin
      load(len, len);
      check("R5 writes alone keep 00", sts, 0);
      check("R10 no avail before ready", tx_avail, 0);
      pulse_rdy();
      check("R2 ready -> 11", sts, 3);
      check("R9 tx_len", tx_len, len);
      drain_pkt("R9 data order", len, 0, len);
      check("R4 sts unchanged by reads", sts, 3);
      pulse_ack();
      check("R2 ack -> 00", sts, 0);
    end

    // R11 overrun + R12 restart + R1 flush
    load(40, 5);
    pulse_rdy();
    wr_byte(8'hEE);
    check("R11 overrun set", overrun, 1);
    check("R11 length unchanged", tx_len, 5);
    rd_byte(b); rd_byte(b); rd_byte(b);
    check("R12 third byte before rewind", b, pat(40, 2));
    tx_restart = 1'b1; @(negedge clk); tx_restart = 1'b0;
    check("R4 sts unchanged by restart", sts, 3);
    drain_pkt("R11 R12 bytes after rewind", 40, 0, 5);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    check("R1 flush sts", sts, 0);
    check("R1 flush overrun", overrun, 0);
    check("R1 flush avail", tx_avail, 0);

    // R3 double buffer ordering
    set_cfg(1, 0, 0, 8, 16);
    for (int k = 1; k <= 4; k++) begin
      load(50 + k, k);
      pulse_rdy();
      check("R3 first commit -> 01", sts, 1);
      load(60 + k, k + 3);
      pulse_rdy();
      check("R3 second commit -> 11", sts, 3);
      check("R3 first length", tx_len, k);
      drain_pkt("R3 first half data", 50 + k, 0, k);
      pulse_ack();
      check("R3 ack -> 01", sts, 1);
      check("R3 second length", tx_len, k + 3);
      drain_pkt("R3 second half data", 60 + k, 0, k + 3);
      pulse_ack();
      check("R3 ack -> 00", sts, 0);
    end

    // R6 auto ready, non-continuous
    set_cfg(0, 1, 0, 4, 16);
    load(70, 3);
    check("R6 short half stays 00", sts, 0);
    wr_byte(pat(70, 3));
    check("R6 auto commit at maxp", sts, 3);
    drain_pkt("R6 data", 70, 0, 4);
    pulse_ack();
    load(71, 2);
    check("R6 short needs set-ready", sts, 0);
    pulse_rdy();
    check("R6 short after set-ready", sts, 3);
    check("R6 short length", tx_len, 2);
    pulse_ack();
    set_cfg(1, 1, 0, 4, 16);
    load(72, 4);
    check("R6 R3 double auto -> 01", sts, 1);
    load(73, 4);
    check("R6 R3 double auto -> 11", sts, 3);
    drain_pkt("R6 double first", 72, 0, 4);
    pulse_ack();
    drain_pkt("R6 double second", 73, 0, 4);
    pulse_ack();
    check("R6 double drained", sts, 0);

    // R7 continuous segmentation sweep, all lengths 1..HD
    set_cfg(0, 0, 1, 4, 16);
    for (int len = 1; len <= HD; len++) begin
      int rem, pos, n;
      load(80 + len, len);
      pulse_rdy();
      rem = len; pos = 0;
      while (rem > 0) begin
        n = (rem > 4) ? 4 : rem;
        check("R7 segment length", tx_len, n);
        drain_pkt("R7 segment data", 80 + len, pos, n);
        pulse_ack();
        rem -= n; pos += n;
        check("R7 status after segment ack", sts, (rem > 0) ? 3 : 0);
      end
    end

    // R8 auto + continuous: commit at buffer size
    set_cfg(0, 1, 1, 4, 12);
    load(90, 11);
    check("R8 below bufsz stays 00", sts, 0);
    wr_byte(pat(90, 11));
    check("R8 commit at bufsz", sts, 3);
    for (int s = 0; s < 3; s++) begin
      check("R8 R7 segment length", tx_len, 4);
      drain_pkt("R8 segment data", 90, s * 4, 4);
      pulse_ack();
    end
    check("R8 drained", sts, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule